// File: doc/BRIEF.md
# Bidirectional Handshake Port

This block is one 8-bit data port that carries traffic in both directions over a single set of pins. The host side writes bytes into an output latch and reads bytes from an input latch; the peripheral side moves data with two active-low handshake inputs. These are a strobe, which captures the pin data, and an acknowledge, which opens the pin drivers. The output latch reaches the pins only while acknowledge is held low. At every other time the pins are released, shown here as a low output-enable.

Each direction has its own interrupt enable. Both enables are changed by single-bit set/reset commands that address bit positions of the companion control port. The two interrupt sources merge onto one interrupt line. A five-bit status field gives the upper bits of the control-port read. Configuration of the neighbouring port and control-word decoding belong to other blocks.

All inputs are taken as already synchronous to `clk`. Reset is synchronous and active high.

Top module: `duplex_hs_port`

## Requirements
- R1: Reset sets `obf_n` to 1 and `ibf` to 0. It clears both latches (`host_rdata` = 0, and `pad_out` = 0 once acknowledged), both interrupt enables, the output-release flag and `intr`.
- R2: `pad_oe` is 1 exactly while `ack_n` is 0. Whenever `pad_oe` is 1, `pad_out` presents the output latch.
- R3: A cycle with `host_wr` = 1 loads `host_wdata` into the output latch and drives `obf_n` to 0 from the next cycle.
- R4: While `obf_n` is 0, a cycle with `ack_n` = 0 and no write returns `obf_n` to 1 in the next cycle and marks the output byte as released. A write in the same cycle as acknowledge takes priority and leaves `obf_n` at 0.
- R5: A cycle with `stb_n` = 0 captures `pad_in` into the input latch, which is visible on `host_rdata`, and sets `ibf` to 1 in the next cycle.
- R6: A cycle with `host_rd` = 1 clears `ibf` in the next cycle. A strobe in the same cycle wins, so `ibf` stays 1 with the new byte.
- R7: A command with `bitop_valid` = 1 and `bitop_sel` = 6 loads `bitop_val` into the output interrupt enable. Selection 4 loads the input interrupt enable. Every other selection leaves both enables unchanged.
- R8: `intr` = (`ibf` AND input enable) OR (released flag AND output enable). A host write clears the released flag.
- R9: `status` bit 4..0 = {`obf_n`, output enable, `ibf`, input enable, `intr`}. These correspond to control-port read bits 7..3.
- R10: The two latches are independent. A host write never changes `host_rdata`, and a strobe never changes `pad_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read of the input latch |
| host_rdata | output | 8 | Input latch contents |
| bitop_valid | input | 1 | Single-bit set/reset command valid |
| bitop_sel | input | 3 | Control-port bit addressed by the command |
| bitop_val | input | 1 | Value written to the addressed bit |
| pad_in | input | 8 | Data seen on the pins |
| pad_out | output | 8 | Data driven on the pins |
| pad_oe | output | 1 | Pin driver enable (0 = released) |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Shared interrupt request |
| status | output | 5 | {obf_n, out enable, ibf, in enable, intr} |

## Verification
The checker watches several rules on every cycle:
- a write pulls the output-full flag low;
- an acknowledge without a write releases that flag;
- a strobe captures the pin byte and raises the input-full flag;
- a read without a strobe drops the input-full flag;
- an enabled full input always raises the interrupt;
- driven pins always carry the last written byte.

Only the bench scenarios show the rest. These are the exact status packing across a sequence of mixed traffic, the priority of a write over a simultaneous acknowledge and of a strobe over a simultaneous read, the ignored bit selections, and the isolation of the two latches after each is touched.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

    localparam int DATA_W    = 8;
    localparam int BSEL_W    = 3;
    localparam int STATUS_W  = 5;
    // control-port bit positions that own the interrupt enables
    localparam logic [BSEL_W-1:0] OUT_EN_SEL = 3'd6;
    localparam logic [BSEL_W-1:0] IN_EN_SEL  = 3'd4;

    typedef struct packed {
        logic valid;
        logic [BSEL_W-1:0] sel;
        logic val;
    } bitop_t;

    typedef struct packed {
        logic obf_n;
        logic out_en;
        logic ibf;
        logic in_en;
        logic intr;
    } hs_status_t;

    function automatic logic [STATUS_W-1:0] pack_status(hs_status_t s);
        return s;
    endfunction

endpackage

// File: rtl/hs_out_side.sv
module hs_out_side
    import hs_port_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ack_n,
    output logic [W-1:0] out_latch,
    output logic         obf_n,
    output logic         released
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_latch <= '0;
            obf_n     <= 1'b1;
            released  <= 1'b0;
        end else if (wr) begin
            out_latch <= wdata;
            obf_n     <= 1'b0;
            released  <= 1'b0;
        end else if (!ack_n && !obf_n) begin
            obf_n     <= 1'b1;
            released  <= 1'b1;
        end
    end
endmodule

// File: rtl/hs_in_side.sv
module hs_in_side
    import hs_port_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb_n,
    input  logic         rd,
    input  logic [W-1:0] pin,
    output logic [W-1:0] in_latch,
    output logic         ibf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_latch <= '0;
            ibf      <= 1'b0;
        end else if (!stb_n) begin
            in_latch <= pin;
            ibf      <= 1'b1;
        end else if (rd) begin
            ibf      <= 1'b0;
        end
    end
endmodule

// File: rtl/hs_irq_ctl.sv
module hs_irq_ctl
    import hs_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  bitop_t bop,
    input  logic   ibf,
    input  logic   released,
    output logic   out_en,
    output logic   in_en,
    output logic   intr
);
    localparam int NSRC = 2;
    // source 0 = input direction, source 1 = output direction
    localparam logic [BSEL_W-1:0] SRC_SEL [NSRC] = '{IN_EN_SEL, OUT_EN_SEL};

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] cond;

    assign cond = {released, ibf};

    for (genvar i = 0; i < NSRC; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst)
                en_q[i] <= 1'b0;
            else if (bop.valid && bop.sel == SRC_SEL[i])
                en_q[i] <= bop.val;
        end
    end

    assign in_en  = en_q[0];
    assign out_en = en_q[1];
    assign intr   = |(en_q & cond);
endmodule

// File: rtl/duplex_hs_port.sv
module duplex_hs_port
    import hs_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                host_rd,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                bitop_valid,
    input  logic [BSEL_W-1:0]   bitop_sel,
    input  logic                bitop_val,
    input  logic [DATA_W-1:0]   pad_in,
    output logic [DATA_W-1:0]   pad_out,
    output logic                pad_oe,
    input  logic                stb_n,
    input  logic                ack_n,
    output logic                obf_n,
    output logic                ibf,
    output logic                intr,
    output logic [STATUS_W-1:0] status
);
    logic       released;
    logic       out_en;
    logic       in_en;
    bitop_t     bop;
    hs_status_t st;

    assign bop = '{valid: bitop_valid, sel: bitop_sel, val: bitop_val};

    hs_out_side #(.W(DATA_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .wr       (host_wr),
        .wdata    (host_wdata),
        .ack_n    (ack_n),
        .out_latch(pad_out),
        .obf_n    (obf_n),
        .released (released)
    );

    hs_in_side #(.W(DATA_W)) u_in (
        .clk     (clk),
        .rst     (rst),
        .stb_n   (stb_n),
        .rd      (host_rd),
        .pin     (pad_in),
        .in_latch(host_rdata),
        .ibf     (ibf)
    );

    hs_irq_ctl u_irq (
        .clk     (clk),
        .rst     (rst),
        .bop     (bop),
        .ibf     (ibf),
        .released(released),
        .out_en  (out_en),
        .in_en   (in_en),
        .intr    (intr)
    );

    // pins are driven only during acknowledge
    assign pad_oe = ~ack_n;

    assign st     = '{obf_n: obf_n, out_en: out_en, ibf: ibf, in_en: in_en, intr: intr};
    assign status = pack_status(st);
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk
    import hs_port_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                host_wr,
    input logic [DATA_W-1:0]   host_wdata,
    input logic                host_rd,
    input logic [DATA_W-1:0]   host_rdata,
    input logic [DATA_W-1:0]   pad_in,
    input logic [DATA_W-1:0]   pad_out,
    input logic                pad_oe,
    input logic                stb_n,
    input logic                ack_n,
    input logic                obf_n,
    input logic                ibf,
    input logic                intr,
    input logic [STATUS_W-1:0] status
);
    // R3
    wr_fills_chk: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> !obf_n);

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !host_wr && !obf_n) |=> obf_n);

    // R5
    stb_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !stb_n |=> (ibf && host_rdata == $past(pad_in)));

    // R6
    rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && stb_n) |=> !ibf);

    // R8
    in_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ibf && status[1]) |-> intr);

    // R2
    drive_data_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe && !$past(rst) && $past(host_wr)) |-> pad_out == $past(host_wdata));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stb_n |=> $stable(host_rdata));
endmodule

bind duplex_hs_port hs_port_chk u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .stb_n(stb_n), .ack_n(ack_n),
    .obf_n(obf_n), .ibf(ibf), .intr(intr), .status(status)
);

// File: tb/duplex_hs_port_test.sv
module duplex_hs_port_test;
    import hs_port_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_wr = 0, host_rd = 0, bitop_valid = 0, bitop_val = 0;
    logic stb_n = 1, ack_n = 1;
    logic [7:0] host_wdata = 0, pad_in = 0;
    logic [2:0] bitop_sel = 0;
    logic [7:0] host_rdata, pad_out;
    logic pad_oe, obf_n, ibf, intr;
    logic [4:0] status;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    duplex_hs_port uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .bitop_valid(bitop_valid),
        .bitop_sel(bitop_sel), .bitop_val(bitop_val), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .stb_n(stb_n), .ack_n(ack_n),
        .obf_n(obf_n), .ibf(ibf), .intr(intr), .status(status)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       rd;
        logic       stbn;
        logic       ackn;
        logic [7:0] pin;
        logic       bv;
        logic [2:0] bsel;
        logic       bval;
        logic       e_obfn;
        logic       e_ibf;
        logic [7:0] e_rdata;
        logic       e_oe;
        logic [7:0] e_pout;
        logic [4:0] e_st;
    } vec_t;

    localparam int NV = 12;
    // status = {obf_n, out_en, ibf, in_en, intr}
    localparam vec_t VECS [NV] = '{
        '{1'b0,8'h00,1'b0,1'b1,1'b1,8'h00,1'b0,3'd0,1'b0, 1'b1,1'b0,8'h00,1'b0,8'h00,5'b10000}, // idle R9
        '{1'b1,8'hAA,1'b0,1'b1,1'b1,8'h00,1'b0,3'd0,1'b0, 1'b0,1'b0,8'h00,1'b0,8'h00,5'b00000}, // R3
        '{1'b0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b0,3'd0,1'b0, 1'b1,1'b0,8'h00,1'b1,8'hAA,5'b10000}, // R4 R2
        '{1'b0,8'h00,1'b0,1'b1,1'b1,8'h00,1'b1,3'd6,1'b1, 1'b1,1'b0,8'h00,1'b0,8'h00,5'b11001}, // R7 R8
        '{1'b1,8'h55,1'b0,1'b1,1'b1,8'h00,1'b0,3'd0,1'b0, 1'b0,1'b0,8'h00,1'b0,8'h00,5'b01000}, // R8 clear
        '{1'b0,8'h00,1'b0,1'b0,1'b1,8'h3C,1'b0,3'd0,1'b0, 1'b0,1'b1,8'h3C,1'b0,8'h00,5'b01100}, // R5
        '{1'b0,8'h00,1'b0,1'b1,1'b1,8'h00,1'b1,3'd4,1'b1, 1'b0,1'b1,8'h3C,1'b0,8'h00,5'b01111}, // R7 R8
        '{1'b0,8'h00,1'b1,1'b1,1'b1,8'h00,1'b0,3'd0,1'b0, 1'b0,1'b0,8'h3C,1'b0,8'h00,5'b01010}, // R6
        '{1'b0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b0,3'd0,1'b0, 1'b1,1'b0,8'h3C,1'b1,8'h55,5'b11011}, // R4 R8
        '{1'b0,8'h00,1'b0,1'b1,1'b1,8'h00,1'b1,3'd6,1'b0, 1'b1,1'b0,8'h3C,1'b0,8'h00,5'b10010}, // R7
        '{1'b0,8'h00,1'b0,1'b1,1'b1,8'h00,1'b1,3'd2,1'b1, 1'b1,1'b0,8'h3C,1'b0,8'h00,5'b10010}, // R7 ignored
        '{1'b0,8'h00,1'b1,1'b0,1'b1,8'hC3,1'b0,3'd0,1'b0, 1'b1,1'b1,8'hC3,1'b0,8'h00,5'b10111}  // R6 priority
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        host_wr = 0; host_rd = 0; bitop_valid = 0; bitop_val = 0; bitop_sel = 0;
        stb_n = 1; ack_n = 1; host_wdata = 0; pad_in = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        step();
        step();
        // R1 reset state
        chk("R1", "obf_n", obf_n, 1);
        chk("R1", "ibf", ibf, 0);
        chk("R1", "intr", intr, 0);
        chk("R1", "status", status, 5'b10000);
        chk("R1", "rdata", host_rdata, 0);
        @(negedge clk);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            host_wr = VECS[i].wr; host_wdata = VECS[i].wd; host_rd = VECS[i].rd;
            stb_n = VECS[i].stbn; ack_n = VECS[i].ackn; pad_in = VECS[i].pin;
            bitop_valid = VECS[i].bv; bitop_sel = VECS[i].bsel; bitop_val = VECS[i].bval;
            step();
            chk("R3", $sformatf("vec%0d obf_n", i), obf_n, VECS[i].e_obfn);
            chk("R5", $sformatf("vec%0d ibf", i), ibf, VECS[i].e_ibf);
            chk("R5", $sformatf("vec%0d rdata", i), host_rdata, VECS[i].e_rdata);
            chk("R2", $sformatf("vec%0d oe", i), pad_oe, VECS[i].e_oe);
            if (VECS[i].e_oe)
                chk("R2", $sformatf("vec%0d pad_out", i), pad_out, VECS[i].e_pout);
            chk("R9", $sformatf("vec%0d status", i), status, VECS[i].e_st);
            chk("R8", $sformatf("vec%0d intr", i), intr, VECS[i].e_st[0]);
        end

        // R1: reset mid-run clears latches and enables
        @(negedge clk);
        idle_inputs();
        rst = 1;
        step();
        @(negedge clk);
        rst = 0;
        chk("R1", "status after reset", status, 5'b10000);
        chk("R1", "rdata after reset", host_rdata, 0);
        ack_n = 0;
        #1;
        chk("R1", "out latch after reset", pad_out, 0);
        step();
        chk("R1", "ack with empty latch keeps obf_n", obf_n, 1);

        // R4: write and acknowledge in the same cycle, write wins
        @(negedge clk);
        host_wr = 1; host_wdata = 8'h77; ack_n = 0;
        step();
        chk("R4", "write beats ack", obf_n, 0);
        chk("R2", "pad_out new byte", pad_out, 8'h77);
        @(negedge clk);
        host_wr = 0;
        step();
        chk("R4", "ack releases next", obf_n, 1);

        // R10: write did not touch input latch; strobe does not touch output latch
        chk("R10", "rdata untouched by write", host_rdata, 0);
        @(negedge clk);
        stb_n = 0; pad_in = 8'h99;
        step();
        chk("R10", "pad_out untouched by strobe", pad_out, 8'h77);
        chk("R5", "strobe capture", host_rdata, 8'h99);

        // R7: unrelated selections leave enables cleared; selection 4 clears input enable
        @(negedge clk);
        stb_n = 1; ack_n = 1;
        bitop_valid = 1; bitop_sel = 3'd5; bitop_val = 1;
        step();
        chk("R7", "sel5 ignored", status, 5'b10100);
        @(negedge clk);
        bitop_sel = 3'd4; bitop_val = 1;
        step();
        chk("R7", "sel4 set", status, 5'b10111);
        @(negedge clk);
        bitop_valid = 0; bitop_val = 0;
        step();
        chk("R7", "no valid no change", status, 5'b10111);
        @(negedge clk);
        bitop_valid = 1; bitop_sel = 3'd4; bitop_val = 0;
        step();
        chk("R7", "sel4 clear", status, 5'b10100);
        chk("R8", "intr off without enable", intr, 0);

        // R8: released output with its enable raises intr; write clears it
        @(negedge clk);
        bitop_sel = 3'd6; bitop_val = 1;
        step();
        chk("R8", "released+enable", intr, 1);
        @(negedge clk);
        bitop_valid = 0; host_wr = 1; host_wdata = 8'h12;
        step();
        chk("R8", "write clears output irq", intr, 0);
        idle_inputs();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule